// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block makes the device-side handshake decisions for endpoint 0 of a USB function during control transfers. A protocol engine hands it decoded events: a received SETUP packet with its direction bit, a received OUT data packet with its length, and an IN token. For each event the block answers with an ACK, a NAK or a request to transmit the single packet bank. It also tracks the SETUP, data and status stages of the transfer.

Four event flags are visible to a CPU, and each has its own clear strobe. The flags are setup-received, OUT-data-received, IN-bank-ready and IN-was-NAKed. The CPU fills the bank one byte per write strobe while the IN-bank-ready flag is set. Clearing that flag commits the bank, and the next IN token sends it. A zero-byte commit therefore sends a zero-length packet, which lets the CPU end the data stage early.

When the host switches direction, the block detects the status stage. The first token of that stage is always NAKed. Entering the status stage of a control read throws away whatever the CPU had placed in the bank, and a CPU clear of the IN-bank-ready flag has no effect from then on. A new SETUP aborts any stage that is in progress.

The stage machine has the following states:
- `ST_IDLE` (code 0): no transfer is active.
- `ST_SETUP_WAIT` (code 1): a SETUP was received and its flag is not yet cleared.
- `ST_DATA_OUT` (code 2): data stage of a control write.
- `ST_DATA_IN` (code 3): data stage of a control read.
- `ST_STATUS_IN` (code 4): status stage of a control write.
- `ST_STATUS_OUT` (code 5): status stage of a control read.
- `ST_DONE` (code 6): the transfer has finished.

The transitions are as follows:
- A SETUP leads from any state to `ST_SETUP_WAIT`.
- `ST_SETUP_WAIT` goes to `ST_DATA_IN` or `ST_DATA_OUT` when the CPU clears the setup flag. The direction latched from the SETUP picks the target.
- `ST_DATA_OUT` goes to `ST_STATUS_IN` on an IN token.
- `ST_DATA_IN` goes to `ST_STATUS_OUT` on an OUT token.
- `ST_STATUS_IN` goes to `ST_DONE` when its committed packet is sent.
- `ST_STATUS_OUT` goes to `ST_DONE` when its OUT token is ACKed.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: While reset is asserted, and at the first output after it: `stage` is 0 (`ST_IDLE`), all four flags are 0, `hs_code` is 0, `tx_send` is 0, `tx_len` is 0 and `rx_len` is 0.
- R2: A `tok_setup` in any state is answered with `hs_code`=1 (ACK) and sets `fl_setup`. It clears `fl_out_rx`, `fl_in_ready` and `fl_in_naked`, and it empties the bank. It moves `stage` to 1 and latches `setup_dir_in`, which is bit 7 of the first SETUP byte (1 means device-to-host). SETUP takes priority over `tok_out` and `tok_in`, and `tok_out` takes priority over `tok_in`.
- R3: In `ST_SETUP_WAIT`, IN and OUT tokens get `hs_code`=2 (NAK). A `clr_stp` while `fl_setup` is set moves `stage` to 3 and sets `fl_in_ready` when the latched direction is 1. When the latched direction is 0 it moves `stage` to 2.
- R4: In `ST_DATA_OUT`, an OUT token while `fl_out_rx` is 0 is ACKed, sets `fl_out_rx` and loads `rx_len` from `out_len`. An OUT token while `fl_out_rx` is 1 is NAKed and leaves `rx_len` unchanged. `clr_out` clears `fl_out_rx`.
- R5: In `ST_DATA_IN`, an IN token while `fl_in_ready` is 1 is NAKed and sets `fl_in_naked`. `clr_nakin` clears `fl_in_naked`.
- R6: In `ST_DATA_IN`, an IN token while `fl_in_ready` is 0 gives `tx_send`=1 with `tx_len` equal to the committed byte count, including 0, and `hs_code`=0. It then sets `fl_in_ready` again and empties the bank.
- R7: A `cpu_wr` adds one byte to the bank only while `fl_in_ready` is 1 and `stage` is 3 or 4. The count saturates at `BANK_BYTES`.
- R8: An OUT token in `ST_DATA_IN` is NAKed, moves `stage` to 5, discards the bank and sets `fl_in_ready`. After that, `clr_txi` has no effect.
- R9: In `ST_STATUS_OUT`, an OUT token is ACKed and moves `stage` to 6, and an IN token is NAKed.
- R10: An IN token in `ST_DATA_OUT` is NAKed, moves `stage` to 4 and sets `fl_in_ready`. In `ST_STATUS_IN` the CPU clears `fl_in_ready`, and the next IN token sends the bank and moves `stage` to 6.
- R11: In `ST_IDLE` and `ST_DONE`, and in any other case not covered above, IN and OUT tokens are NAKed.
- R12: When a hardware set and a CPU clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | SETUP packet received (one-cycle pulse) |
| setup_dir_in | input | 1 | Bit 7 of the first SETUP byte, qualified by `tok_setup` |
| tok_out | input | 1 | OUT data packet received (one-cycle pulse) |
| out_len | input | LEN_W | Byte count of the OUT packet |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| clr_stp | input | 1 | CPU clear of `fl_setup` |
| clr_out | input | 1 | CPU clear of `fl_out_rx` (frees the bank) |
| clr_txi | input | 1 | CPU clear of `fl_in_ready` (commits the bank) |
| clr_nakin | input | 1 | CPU clear of `fl_in_naked` |
| cpu_wr | input | 1 | CPU writes one byte into the bank |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK |
| tx_send | output | 1 | Send the bank as an IN data packet |
| tx_len | output | LEN_W | Byte count to send, valid with `tx_send`, else 0 |
| stage | output | 3 | Stage code (see state list) |
| fl_setup | output | 1 | SETUP-received flag |
| fl_out_rx | output | 1 | OUT-data-received flag |
| fl_in_ready | output | 1 | Bank-ready-for-IN-data flag |
| fl_in_naked | output | 1 | IN-token-NAKed flag |
| rx_len | output | LEN_W | Length of the last ACKed OUT packet |

## Verification
Every result is registered. An event or strobe presented before clock edge k shows on `hs_code`, `tx_send`, `tx_len`, `stage`, the flags and `rx_len` directly after edge k. No result is due later, and none shows earlier. The bench drives inputs at the falling edge, so they are stable for edge k. A behavioural model steps at that same rising edge, and every output is compared with it at the next falling edge. Same-cycle collisions are driven on purpose to check the set-over-clear and priority rules: SETUP together with a clear, a NAKed IN together with its clear, and a write together with a discard.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SETUP_WAIT = 3'd1,
        ST_DATA_OUT   = 3'd2,
        ST_DATA_IN    = 3'd3,
        ST_STATUS_IN  = 3'd4,
        ST_STATUS_OUT = 3'd5,
        ST_DONE       = 3'd6
    } ep0_stage_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_code_e;

    localparam int FL_STP    = 0;
    localparam int FL_OUT    = 1;
    localparam int FL_TXI    = 2;
    localparam int FL_NAKIN  = 3;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                q_o[g] <= 1'b1;          // hardware set dominates
            end else if (clr_i[g]) begin
                q_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ep0_pkt_bank.sv
module ep0_pkt_bank #(
    parameter int BANK_BYTES = 64,
    parameter int LEN_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_i,
    input  logic             cap_i,
    input  logic [LEN_W-1:0] cap_len_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] rx_len_o
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(BANK_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (wr_i && (cnt_o < FULL)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_len_o <= '0;
        end else if (cap_i) begin
            rx_len_o <= cap_len_i;
        end
    end
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import usb_ep0_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_setup,
    input  logic                 setup_dir_in,
    input  logic                 tok_out,
    input  logic                 tok_in,
    input  logic [NUM_FLAGS-1:0] cpu_clr,
    input  logic                 cpu_wr,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [LEN_W-1:0]     bank_cnt,
    output logic [NUM_FLAGS-1:0] flag_set,
    output logic [NUM_FLAGS-1:0] flag_clr,
    output logic                 bank_clear,
    output logic                 bank_wr,
    output logic                 rx_cap,
    output ep0_stage_e           stage_q,
    output hs_code_e             hs_q,
    output logic                 send_q,
    output logic [LEN_W-1:0]     send_len_q
);
    ep0_stage_e           stage_d;
    hs_code_e             hs_d;
    logic                 send_d;
    logic                 dir_q;
    logic                 bank_stage;
    logic                 stp_release;
    logic [NUM_FLAGS-1:0] hw_clr;

    assign bank_stage  = (stage_q == ST_DATA_IN) || (stage_q == ST_STATUS_IN);
    assign stp_release = !tok_setup && (stage_q == ST_SETUP_WAIT)
                         && flags[FL_STP] && cpu_clr[FL_STP];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            if (tok_setup) begin
                dir_q <= setup_dir_in;
            end
        end
    end

    // next stage
    always_comb begin
        stage_d = stage_q;
        if (tok_setup) begin
            stage_d = ST_SETUP_WAIT;
        end else if (stp_release) begin
            stage_d = dir_q ? ST_DATA_IN : ST_DATA_OUT;
        end else if (tok_out) begin
            unique case (stage_q)
                ST_DATA_IN:    stage_d = ST_STATUS_OUT;
                ST_STATUS_OUT: stage_d = ST_DONE;
                default:       stage_d = stage_q;
            endcase
        end else if (tok_in) begin
            unique case (stage_q)
                ST_DATA_OUT:  stage_d = ST_STATUS_IN;
                ST_STATUS_IN: stage_d = flags[FL_TXI] ? ST_STATUS_IN : ST_DONE;
                default:      stage_d = stage_q;
            endcase
        end
    end

    // outputs: handshake decision, flag and bank strobes
    always_comb begin
        hs_d       = HS_NONE;
        send_d     = 1'b0;
        flag_set   = '0;
        hw_clr     = '0;
        bank_clear = 1'b0;
        rx_cap     = 1'b0;
        if (tok_setup) begin
            hs_d              = HS_ACK;
            flag_set[FL_STP]  = 1'b1;
            hw_clr[FL_OUT]    = 1'b1;
            hw_clr[FL_TXI]    = 1'b1;
            hw_clr[FL_NAKIN]  = 1'b1;
            bank_clear        = 1'b1;
        end else begin
            if (tok_out) begin
                unique case (stage_q)
                    ST_DATA_OUT: begin
                        if (flags[FL_OUT]) begin
                            hs_d = HS_NAK;
                        end else begin
                            hs_d             = HS_ACK;
                            flag_set[FL_OUT] = 1'b1;
                            rx_cap           = 1'b1;
                        end
                    end
                    ST_DATA_IN: begin
                        hs_d             = HS_NAK;   // first status token
                        flag_set[FL_TXI] = 1'b1;
                        bank_clear       = 1'b1;     // discard CPU data
                    end
                    ST_STATUS_OUT: hs_d = HS_ACK;
                    default:       hs_d = HS_NAK;
                endcase
            end else if (tok_in) begin
                unique case (stage_q)
                    ST_DATA_IN: begin
                        if (flags[FL_TXI]) begin
                            hs_d               = HS_NAK;
                            flag_set[FL_NAKIN] = 1'b1;
                        end else begin
                            send_d           = 1'b1;
                            flag_set[FL_TXI] = 1'b1;
                            bank_clear       = 1'b1;
                        end
                    end
                    ST_DATA_OUT: begin
                        hs_d             = HS_NAK;   // first status token
                        flag_set[FL_TXI] = 1'b1;
                        bank_clear       = 1'b1;
                    end
                    ST_STATUS_IN: begin
                        if (flags[FL_TXI]) begin
                            hs_d = HS_NAK;
                        end else begin
                            send_d     = 1'b1;
                            bank_clear = 1'b1;
                        end
                    end
                    default: hs_d = HS_NAK;
                endcase
            end
            if (stp_release && dir_q) begin
                flag_set[FL_TXI] = 1'b1;
            end
        end
    end

    assign flag_clr = hw_clr | {cpu_clr[FL_NAKIN],
                                cpu_clr[FL_TXI] & bank_stage,
                                cpu_clr[FL_OUT],
                                cpu_clr[FL_STP]};
    assign bank_wr  = cpu_wr && flags[FL_TXI] && bank_stage;

    // registered decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q       <= HS_NONE;
            send_q     <= 1'b0;
            send_len_q <= '0;
        end else begin
            hs_q       <= hs_d;
            send_q     <= send_d;
            send_len_q <= send_d ? bank_cnt : '0;
        end
    end
endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
    import usb_ep0_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int LEN_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_setup,
    input  logic             setup_dir_in,
    input  logic             tok_out,
    input  logic [LEN_W-1:0] out_len,
    input  logic             tok_in,
    input  logic             clr_stp,
    input  logic             clr_out,
    input  logic             clr_txi,
    input  logic             clr_nakin,
    input  logic             cpu_wr,
    output logic [1:0]       hs_code,
    output logic             tx_send,
    output logic [LEN_W-1:0] tx_len,
    output logic [2:0]       stage,
    output logic             fl_setup,
    output logic             fl_out_rx,
    output logic             fl_in_ready,
    output logic             fl_in_naked,
    output logic [LEN_W-1:0] rx_len
);
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] cpu_clr;
    logic                 bank_clear;
    logic                 bank_wr;
    logic                 rx_cap;
    logic [LEN_W-1:0]     bank_cnt;
    ep0_stage_e           stage_q;
    hs_code_e             hs_q;

    assign cpu_clr = {clr_nakin, clr_txi, clr_out, clr_stp};

    ep0_stage_fsm #(.LEN_W(LEN_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tok_setup    (tok_setup),
        .setup_dir_in (setup_dir_in),
        .tok_out      (tok_out),
        .tok_in       (tok_in),
        .cpu_clr      (cpu_clr),
        .cpu_wr       (cpu_wr),
        .flags        (flags),
        .bank_cnt     (bank_cnt),
        .flag_set     (flag_set),
        .flag_clr     (flag_clr),
        .bank_clear   (bank_clear),
        .bank_wr      (bank_wr),
        .rx_cap       (rx_cap),
        .stage_q      (stage_q),
        .hs_q         (hs_q),
        .send_q       (tx_send),
        .send_len_q   (tx_len)
    );

    ep0_flag_bank #(.N(NUM_FLAGS)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flags)
    );

    ep0_pkt_bank #(.BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (bank_clear),
        .wr_i      (bank_wr),
        .cap_i     (rx_cap),
        .cap_len_i (out_len),
        .cnt_o     (bank_cnt),
        .rx_len_o  (rx_len)
    );

    assign hs_code     = hs_q;
    assign stage       = stage_q;
    assign fl_setup    = flags[FL_STP];
    assign fl_out_rx   = flags[FL_OUT];
    assign fl_in_ready = flags[FL_TXI];
    assign fl_in_naked = flags[FL_NAKIN];
endmodule

// File: rtl/usb_ep0_ctrl_chk.sv
module usb_ep0_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_setup,
    input logic       tok_out,
    input logic       tok_in,
    input logic       clr_stp,
    input logic [1:0] hs_code,
    input logic       tx_send,
    input logic [2:0] stage,
    input logic       fl_setup,
    input logic       fl_in_ready,
    input logic       fl_in_naked
);
    AST_SETUP_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> (hs_code == 2'd1) && fl_setup && (stage == 3'd1)); // R2

    AST_STATUS_FIRST_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd3 && tok_out && !tok_setup) |=> (hs_code == 2'd2) && (stage == 3'd5)); // R8

    AST_NAKED_IN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd3 && tok_in && !tok_out && !tok_setup && fl_in_ready)
        |=> fl_in_naked && (hs_code == 2'd2)); // R5

    AST_SEND_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |-> (hs_code == 2'd0)); // R6

    AST_STATUS_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd5 && !tok_setup) |=> fl_in_ready); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_setup && clr_stp) |=> fl_setup); // R12
endmodule

bind usb_ep0_ctrl usb_ep0_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_setup   (tok_setup),
    .tok_out     (tok_out),
    .tok_in      (tok_in),
    .clr_stp     (clr_stp),
    .hs_code     (hs_code),
    .tx_send     (tx_send),
    .stage       (stage),
    .fl_setup    (fl_setup),
    .fl_in_ready (fl_in_ready),
    .fl_in_naked (fl_in_naked)
);

// File: tb/usb_ep0_ctrl_tb_top.sv
module usb_ep0_ctrl_tb_top;
    localparam int BANK = 64;
    localparam int LW   = $clog2(BANK + 1);
    localparam int WDOG = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_setup = 0, setup_dir_in = 0, tok_out = 0, tok_in = 0;
    logic [LW-1:0] out_len = '0;
    logic clr_stp = 0, clr_out = 0, clr_txi = 0, clr_nakin = 0, cpu_wr = 0;
    logic [1:0] hs_code;
    logic tx_send, fl_setup, fl_out_rx, fl_in_ready, fl_in_naked;
    logic [LW-1:0] tx_len, rx_len;
    logic [2:0] stage;

    always #4 clk = ~clk;   // 125 MHz

    usb_ep0_ctrl #(.BANK_BYTES(BANK)) dut_i (
        .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .setup_dir_in(setup_dir_in),
        .tok_out(tok_out), .out_len(out_len), .tok_in(tok_in), .clr_stp(clr_stp),
        .clr_out(clr_out), .clr_txi(clr_txi), .clr_nakin(clr_nakin), .cpu_wr(cpu_wr),
        .hs_code(hs_code), .tx_send(tx_send), .tx_len(tx_len), .stage(stage),
        .fl_setup(fl_setup), .fl_out_rx(fl_out_rx), .fl_in_ready(fl_in_ready),
        .fl_in_naked(fl_in_naked), .rx_len(rx_len)
    );

    // behavioural reference model
    int m_st = 0, m_dir = 0, m_cnt = 0, m_rx = 0;
    int m_stp = 0, m_out = 0, m_txi = 0, m_nak = 0;
    int m_hs = 0, m_send = 0, m_len = 0;
    int vectors = 0, miscompares = 0, cycles = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        int st, stp, o, txi, nak, cnt;
        bit bankst;
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_cnt = 0; m_rx = 0;
            m_stp = 0; m_out = 0; m_txi = 0; m_nak = 0;
            m_hs = 0; m_send = 0; m_len = 0;
        end else begin
            st = m_st; stp = m_stp; o = m_out; txi = m_txi; nak = m_nak; cnt = m_cnt;
            bankst = (st == 3 || st == 4);
            m_hs = 0; m_send = 0; m_len = 0;
            if (clr_stp) m_stp = 0;
            if (clr_out) m_out = 0;
            if (clr_nakin) m_nak = 0;
            if (clr_txi && bankst) m_txi = 0;
            if (cpu_wr && txi == 1 && bankst && cnt < BANK) m_cnt = cnt + 1;
            if (tok_setup) begin
                m_st = 1; m_stp = 1; m_out = 0; m_txi = 0; m_nak = 0; m_cnt = 0;
                m_dir = setup_dir_in; m_hs = 1;
            end else begin
                if (tok_out) begin
                    if (st == 2) begin
                        if (o == 1) m_hs = 2;
                        else begin m_hs = 1; m_out = 1; m_rx = out_len; end
                    end else if (st == 3) begin
                        m_hs = 2; m_st = 5; m_cnt = 0; m_txi = 1;
                    end else if (st == 5) begin
                        m_hs = 1; m_st = 6;
                    end else m_hs = 2;
                end else if (tok_in) begin
                    if (st == 3) begin
                        if (txi == 1) begin m_hs = 2; m_nak = 1; end
                        else begin m_send = 1; m_len = cnt; m_cnt = 0; m_txi = 1; end
                    end else if (st == 2) begin
                        m_hs = 2; m_st = 4; m_txi = 1; m_cnt = 0;
                    end else if (st == 4) begin
                        if (txi == 1) m_hs = 2;
                        else begin m_send = 1; m_len = cnt; m_cnt = 0; m_st = 6; end
                    end else m_hs = 2;
                end
                if (st == 1 && stp == 1 && clr_stp) begin
                    m_st = (m_dir == 1) ? 3 : 2;
                    if (m_dir == 1) m_txi = 1;
                end
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        vectors++;
        cmp("hs_code", int'(hs_code), m_hs);
        cmp("tx_send", int'(tx_send), m_send);
        cmp("tx_len", int'(tx_len), m_len);
        cmp("stage", int'(stage), m_st);
        cmp("fl_setup", int'(fl_setup), m_stp);
        cmp("fl_out_rx", int'(fl_out_rx), m_out);
        cmp("fl_in_ready", int'(fl_in_ready), m_txi);
        cmp("fl_in_naked", int'(fl_in_naked), m_nak);
        cmp("rx_len", int'(rx_len), m_rx);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            miscompares++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // one cycle of stimulus, entered and left at a falling edge
    task automatic cyc(input bit s = 0, input bit d = 0, input bit o = 0, input int len = 0,
                       input bit i = 0, input bit cs = 0, input bit co = 0,
                       input bit ct = 0, input bit cn = 0, input bit w = 0);
        tok_setup = s; setup_dir_in = d; tok_out = o; out_len = LW'(len); tok_in = i;
        clr_stp = cs; clr_out = co; clr_txi = ct; clr_nakin = cn; cpu_wr = w;
        @(negedge clk);
        tok_setup = 0; setup_dir_in = 0; tok_out = 0; out_len = '0; tok_in = 0;
        clr_stp = 0; clr_out = 0; clr_txi = 0; clr_nakin = 0; cpu_wr = 0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        cur_req = "R11";                       // idle tokens NAKed
        cyc(.i(1)); cyc(.o(1), .len(4));
        // control read
        cur_req = "R2";  cyc(.s(1), .d(1));
        cur_req = "R3";  cyc(.i(1)); cyc(.o(1)); cyc(.cs(1)); cyc();
        cur_req = "R7";  repeat (5) cyc(.w(1));
        cur_req = "R5";  cyc(.i(1)); cyc(.cn(1));
        cur_req = "R6";  cyc(.ct(1)); cyc(.w(1)); cyc(.i(1)); cyc();
        cur_req = "R7";  repeat (70) cyc(.w(1));
        cur_req = "R6";  cyc(.ct(1)); cyc(.i(1));
        cyc(.ct(1)); cyc(.i(1));                // zero-length anticipation
        cur_req = "R12"; cyc(.i(1), .cn(1)); cyc(.cn(1));
        cur_req = "R8";  repeat (3) cyc(.w(1));
        cyc(.o(1), .w(1)); cyc(.ct(1)); cyc(.w(1)); cyc(.ct(1)); cyc();
        cur_req = "R9";  cyc(.i(1)); cyc(.o(1));
        cur_req = "R11"; cyc(.i(1)); cyc(.o(1)); cyc(.w(1), .ct(1));
        // control write
        cur_req = "R12"; cyc(.s(1), .d(0), .cs(1)); cyc();
        cur_req = "R3";  cyc(.cs(1));
        cur_req = "R4";  cyc(.o(1), .len(8)); cyc(.o(1), .len(3)); cyc(.o(1), .len(5), .co(1));
        cyc(.co(1)); cyc(.o(1), .len(0)); cyc(.co(1)); cyc(.o(1), .len(64));
        cur_req = "R10"; cyc(.i(1)); cyc(.i(1)); cyc(.w(1)); cyc(.ct(1)); cyc(.i(1)); cyc();
        // abort of a read by a new SETUP
        cur_req = "R2";  cyc(.s(1), .d(1)); cyc(.cs(1)); cyc(.w(1)); cyc(.w(1));
        cyc(.s(1), .d(1), .w(1)); cyc(.cs(1)); cyc(.ct(1)); cyc(.i(1)); cyc();
        cur_req = "R10"; cyc(.s(1), .d(0)); cyc(.cs(1)); cyc(.i(1)); cyc(.ct(1), .w(1));
        cyc(.w(1)); cyc(.ct(1)); cyc(.i(1)); cyc();
        cur_req = "R1";  rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule